// File: doc/BRIEF.md
# Masked Condition and Branch Decision Unit

This unit settles, once per descriptor completion, three independent questions for a descriptor-driven DMA channel: whether to raise an interrupt, whether to hold the channel in a wait, and whether to branch. Each question has its own two-bit mode field and its own select register. A select register packs a four-bit mask and a four-bit compare value. The mask chooses which of the channel's four device-status bits take part in the match.

The surrounding channel sequencer pulses `eval` in the cycle a descriptor completes. In that cycle it presents the mode fields, the select registers, the device status, the current command pointer and the descriptor's dependent word. All three decisions come from that one set of inputs. One clock later the unit presents the results: an interrupt pulse, a held wait flag, the next command pointer and a branch-taken flag. A wait decision takes precedence over the other two. It suppresses the interrupt, and it leaves the pointer and the branch flag where they were, so that the same descriptor can be completed again later. A wrapper outside this unit latches the pulse into a software-cleared interrupt level.

Top module: `cond_branch_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `intr_pulse`, `wait_flag`, `bt_flag` and `next_ptr` are all zero.
- R2: A select register carries its mask in bits 19:16 and its compare value in bits 3:0. Its condition is true when (status AND mask) equals (value AND mask), so a zero mask always gives a true condition.
- R3: The mode encoding is the same for all three decisions: 0 never acts, 1 acts when the condition is true, 2 acts when the condition is false, and 3 always acts.
- R4: When `eval` is high at a clock edge and the interrupt decision (`intr_mode` with `intr_sel`) acts, `intr_pulse` is high for exactly the following cycle. Otherwise it is low.
- R5: At each clock edge where `eval` is high, `wait_flag` takes the wait decision (`wait_mode` with `wait_sel`) and holds it until the next such edge.
- R6: If the wait decision acts, that completion raises no interrupt pulse, and `next_ptr` and `bt_flag` keep their previous values.
- R7: On a completion without wait where the branch decision (`br_mode` with `br_sel`) does not act, `next_ptr` becomes `cur_ptr` + 16, wrapping modulo 2^32, and `bt_flag` is cleared.
- R8: On a completion without wait where the branch decision acts, `next_ptr` becomes `dep_word` and `bt_flag` is set.
- R9: At edges where `eval` is low, `next_ptr`, `bt_flag` and `wait_flag` hold, and `intr_pulse` is low the following cycle.
- R10: All three decisions use the inputs sampled at the `eval` edge only. Changes to status, selects or pointers in later cycles do not alter the results until the next `eval`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval | input | 1 | Descriptor completion strobe |
| intr_mode | input | 2 | Interrupt mode field |
| wait_mode | input | 2 | Wait mode field |
| br_mode | input | 2 | Branch mode field |
| intr_sel | input | 32 | Interrupt select register |
| wait_sel | input | 32 | Wait select register |
| br_sel | input | 32 | Branch select register |
| dev_status | input | 4 | Channel device-status bits |
| cur_ptr | input | 32 | Current command pointer |
| dep_word | input | 32 | Descriptor dependent word (branch target) |
| intr_pulse | output | 1 | One-cycle interrupt request |
| wait_flag | output | 1 | Latest wait decision |
| next_ptr | output | 32 | Next command pointer |
| bt_flag | output | 1 | Branch taken on latest advance |

## Verification
A wrong mask or value slice, or an inverted mode decode, appears at the ports on the cycle right after the affected `eval`. It shows as a missing or extra `intr_pulse`, a wrong `wait_flag`, or a pointer that steps by 16 when it should jump. A broken wait precedence shows the same way: a pulse appears alongside a set wait flag, or the pointer moves when it should not. A register that does not hold between completions shows as a drift in `next_ptr` or `bt_flag` during idle cycles. The bench therefore compares every output against its model on every clock, so any such fault is caught within one cycle of its cause.

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int STAT_W   = 4,
  parameter int PTR_W    = 32,
  parameter int SEL_W    = 32,
  parameter int MASK_LSB = 16,
  parameter int STEP     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval,
  input  logic [1:0]       intr_mode,
  input  logic [1:0]       wait_mode,
  input  logic [1:0]       br_mode,
  input  logic [SEL_W-1:0] intr_sel,
  input  logic [SEL_W-1:0] wait_sel,
  input  logic [SEL_W-1:0] br_sel,
  input  logic [STAT_W-1:0] dev_status,
  input  logic [PTR_W-1:0] cur_ptr,
  input  logic [PTR_W-1:0] dep_word,
  output logic             intr_pulse,
  output logic             wait_flag,
  output logic [PTR_W-1:0] next_ptr,
  output logic             bt_flag
);

  localparam logic [1:0] M_NEVER = 2'd0;
  localparam logic [1:0] M_IFSET = 2'd1;
  localparam logic [1:0] M_IFCLR = 2'd2;
  localparam logic [PTR_W-1:0] INC = PTR_W'(STEP);

  function automatic logic decide(input logic [1:0] mode,
                                  input logic [SEL_W-1:0] sel,
                                  input logic [STAT_W-1:0] stat);
    logic [STAT_W-1:0] msk;
    logic hit;
    msk = sel[MASK_LSB +: STAT_W];
    hit = ((stat & msk) == (sel[STAT_W-1:0] & msk));
    case (mode)
      M_NEVER: decide = 1'b0;
      M_IFSET: decide = hit;
      M_IFCLR: decide = !hit;
      default: decide = 1'b1;
    endcase
  endfunction

  logic do_intr, do_wait, do_br;
  assign do_intr = decide(intr_mode, intr_sel, dev_status);
  assign do_wait = decide(wait_mode, wait_sel, dev_status);
  assign do_br   = decide(br_mode,   br_sel,   dev_status);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intr_pulse <= 1'b0;
      wait_flag  <= 1'b0;
      next_ptr   <= '0;
      bt_flag    <= 1'b0;
    end else begin
      intr_pulse <= eval && !do_wait && do_intr;
      if (eval) begin
        wait_flag <= do_wait;
        if (!do_wait) begin
          next_ptr <= do_br ? dep_word : cur_ptr + INC;
          bt_flag  <= do_br;
        end
      end
    end
  end

  // R4: a pulse only follows a completion edge
  a_r4_pulse_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
    intr_pulse |-> ($past(eval) && $past(rst_n)));

  // R6: wait blocks the interrupt of the same completion
  a_r6_wait_blocks_intr: assert property (@(posedge clk) disable iff (!rst_n)
    !(intr_pulse && wait_flag));

  // R9: state holds across idle edges
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(eval)) |-> ($stable(next_ptr) && $stable(bt_flag) && $stable(wait_flag)));

  // R7: sequential advance
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(eval) && !wait_flag && !bt_flag) |-> (next_ptr == $past(cur_ptr) + INC));

  // R8: branch target taken
  a_r8_jump: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(eval) && !wait_flag && bt_flag) |-> (next_ptr == $past(dep_word)));

  // R6: a waiting completion leaves the pointer alone
  a_r6_wait_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wait_flag) |-> ($stable(next_ptr) && $stable(bt_flag)));

endmodule

// File: tb/cond_branch_unit_tb.sv
module cond_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval = 1'b0;
  logic [1:0]  intr_mode = '0, wait_mode = '0, br_mode = '0;
  logic [31:0] intr_sel = '0, wait_sel = '0, br_sel = '0;
  logic [3:0]  dev_status = '0;
  logic [31:0] cur_ptr = '0, dep_word = '0;
  logic        intr_pulse, wait_flag, bt_flag;
  logic [31:0] next_ptr;

  int compared = 0, mismatched = 0;
  bit done = 0;

  bit          e_intr = 0, e_wait = 0, e_bt = 0;
  logic [31:0] e_ptr = '0;

  always #2.5 clk = ~clk;

  cond_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .eval(eval),
    .intr_mode(intr_mode), .wait_mode(wait_mode), .br_mode(br_mode),
    .intr_sel(intr_sel), .wait_sel(wait_sel), .br_sel(br_sel),
    .dev_status(dev_status), .cur_ptr(cur_ptr), .dep_word(dep_word),
    .intr_pulse(intr_pulse), .wait_flag(wait_flag),
    .next_ptr(next_ptr), .bt_flag(bt_flag));

  // model of R2/R3: bitwise mask walk, then mode table
  function automatic bit fires(input int mode, input logic [31:0] sel, input logic [3:0] st);
    bit match = 1;
    for (int i = 0; i < 4; i++)
      if (sel[16+i] && (st[i] != sel[i])) match = 0;
    if (mode == 0) return 0;
    if (mode == 3) return 1;
    if (mode == 1) return match;
    return !match;
  endfunction

  task automatic cmp(input string tag);
    compared++;
    if (intr_pulse !== e_intr || wait_flag !== e_wait || bt_flag !== e_bt || next_ptr !== e_ptr) begin
      mismatched++;
      $display("FAIL %s: got intr=%0b wait=%0b bt=%0b ptr=%h expected intr=%0b wait=%0b bt=%0b ptr=%h",
               tag, intr_pulse, wait_flag, bt_flag, next_ptr, e_intr, e_wait, e_bt, e_ptr);
    end
  endtask

  // drive one cycle of inputs, predict, and check after the edge
  task automatic step(input bit ev, input int im, input int wm, input int bm,
                      input logic [31:0] is, input logic [31:0] ws, input logic [31:0] bs,
                      input logic [3:0] st, input logic [31:0] cp, input logic [31:0] dw,
                      input string tag);
    bit w, fi, fb;
    eval = ev; intr_mode = 2'(im); wait_mode = 2'(wm); br_mode = 2'(bm);
    intr_sel = is; wait_sel = ws; br_sel = bs; dev_status = st;
    cur_ptr = cp; dep_word = dw;
    w = fires(wm, ws, st); fi = fires(im, is, st); fb = fires(bm, bs, st);
    e_intr = ev && !w && fi;
    if (ev) begin
      e_wait = w;
      if (!w) begin
        e_ptr = fb ? dw : cp + 32'd16;
        e_bt = fb;
      end
    end
    @(posedge clk); @(negedge clk);
    cmp(tag);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with eval driven high during reset
    eval = 1'b1; intr_mode = 2'd3; cur_ptr = 32'h100;
    repeat (3) @(negedge clk);
    cmp("R1 in reset");
    @(negedge clk); rst_n = 1'b1; eval = 1'b0;
    @(posedge clk); @(negedge clk);
    cmp("R1 after reset");

    // R7: plain advance, R8: always branch
    step(1, 0, 0, 0, 0, 0, 0, 4'h0, 32'h1000, 32'h5000, "R7 never branch");
    step(1, 3, 0, 3, 0, 0, 0, 4'h0, 32'h1010, 32'h5000, "R8 always branch, R4 always intr");
    // R9: idle holds, pulse drops
    step(0, 3, 3, 0, 0, 0, 0, 4'hF, 32'hAAAA, 32'hBBBB, "R9 idle");
    // R2: mask bit 16 selects status bit0; value bit0
    step(1, 1, 0, 1, 32'h0001_0001, 0, 32'h0001_0000, 4'h1, 32'h2000, 32'h3000, "R2 mask/value match");
    step(1, 2, 0, 2, 32'h0001_0001, 0, 32'h0001_0000, 4'h1, 32'h2000, 32'h3000, "R3 if-clear");
    // R2: zero mask is always a match
    step(1, 2, 0, 1, 32'h0000_000F, 0, 32'h0000_000A, 4'h5, 32'h40, 32'h80, "R2 zero mask");
    // R6: wait blocks interrupt and pointer
    step(1, 3, 3, 3, 0, 0, 0, 4'h0, 32'h7000, 32'h9000, "R6 wait always");
    step(1, 3, 1, 0, 0, 32'h000C_0004, 0, 4'h4, 32'h7000, 32'h9000, "R6 wait if-set");
    step(1, 3, 2, 0, 0, 32'h000C_0004, 0, 4'h4, 32'h7000, 32'h9000, "R5 wait if-clear false");
    // R7: wrap
    step(1, 0, 0, 0, 0, 0, 0, 4'h0, 32'hFFFF_FFF0, 0, "R7 wrap");
    // R10: inputs change after eval; no effect
    step(1, 1, 0, 1, 32'h000F_0003, 0, 32'h000F_0003, 4'h3, 32'h500, 32'h600, "R10 snapshot");
    step(0, 2, 3, 2, 32'h000F_0003, 32'h0, 32'h000F_0003, 4'h0, 32'h999, 32'h888, "R10 later change");
    // R5: wait flag held over idle
    step(1, 0, 3, 0, 0, 0, 0, 4'h0, 32'h10, 32'h20, "R5 set");
    step(0, 0, 0, 0, 0, 0, 0, 4'h0, 32'h10, 32'h20, "R5 hold");
    step(1, 0, 0, 0, 0, 0, 0, 4'h0, 32'h10, 32'h20, "R5 clear");

    // R2/R3/R4/R8: random patterns
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
           $urandom & 32'h000F_000F, $urandom & 32'h000F_000F, $urandom & 32'h000F_000F,
           4'($urandom), $urandom, $urandom, "R3 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule